// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the raster timing for a tile-based video system from one pixel clock. It makes active-low horizontal sync, vertical sync and composite blanking, an active-low raster interrupt, and the active-area pixel and line positions used by downstream tile fetch logic. Every line starts where horizontal sync releases. The line then runs left border, active pixels, right border and finally the sync pulse. Frames are built the same way from lines.

A static parameter picks one of two timing profiles. The low-resolution profile has 400 clocks by 262 lines. The high-resolution profile has 656 clocks by 424 lines. A timing record parameter can replace either profile, for example with a scaled-down geometry. A host-written mode input selects an extended frame of 512 lines in the high-resolution profile. This mode is degenerate on purpose. Vertical sync keeps its usual lines, but the display stays enabled from the end of the top border to the end of the frame, including during the sync pulse. The mode input is taken only at a frame boundary.

Top module: `vid_timing_gen`

## Requirements
- R1: Within a line of HT clocks, the horizontal counter runs left border, active window, right border and sync. `hsync_n` is low for exactly the last H_SW clocks of each line and high for all other clocks (low-res: 29/321/18/32 of 400; high-res: 69/496/43/48 of 656).
- R2: Within a frame, `vsync_n` is low for exactly the last V_SW lines of the normal frame (line indices VT-V_SW to VT-1) and high otherwise. Its edges coincide with `hsync_n` rising edges (low-res: 20/224/14/4 of 262; high-res: 25/384/11/4 of 424).
- R3: `blank_n` is high only when the pixel lies in the horizontal active window and the line lies in the vertical active window.
- R4: `irq_n` falls together with the `hsync_n` falling edge at the end of active line IRQ_L (222 in the low-res profile). It rises with the `hsync_n` falling edge at the end of the next line, so it is low for exactly HT clocks once per frame.
- R5: `pix_x` equals the clock offset from the first active pixel while horizontally active. `line_y` equals the line offset from the first active line while vertically active. Both hold their last value outside those windows.
- R6: After reset, the block sits at pixel 0 of line 0, which is the first left-border clock of the first top-border line. At that point `hsync_n`=1, `vsync_n`=1, `blank_n`=0, `irq_n`=1, `pix_x`=0 and `line_y`=0.
- R7: With the extended mode in effect on a profile that supports it, the frame is VEXT lines long (512 in high-res). The vertical active window runs from line V_TB to the last line, including the sync lines, and `vsync_n` stays on its normal lines.
- R8: `ext_mode` takes effect only at a frame boundary. A mid-frame change alters nothing until the next frame starts.
- R9: In a profile without the extended mode (low-res), `ext_mode` has no effect on any output.
- R10: The line counter advances exactly once per line, on the clock where `hsync_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_mode | input | 1 | Host mode bit: 1 requests the extended frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Composite blanking, low outside the active area |
| irq_n | output | 1 | Raster interrupt, active low for one line |
| pix_x | output | clog2(active pixels) | Active-area pixel position |
| line_y | output | clog2(longest frame) | Active-area line position |

## Verification
The full low-resolution profile is swept clock by clock through a whole frame and across the frame wrap, with the mode bit held at 1. This separates correct interval lengths and orderings from off-by-one placement of sync, blanking and the interrupt line, and it shows that the mode bit is ignored there. A scaled-down geometry with the extended mode enabled runs through hundreds of frames. In that run the mode bit toggles at times unrelated to the frame length, so most writes land mid-frame. This separates a frame-boundary mode sample from an immediate one, and the extended window from the normal one. Every output is compared every clock against an arithmetic model built from cycle counts.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef struct packed {
    logic [15:0] h_lb;
    logic [15:0] h_act;
    logic [15:0] h_rb;
    logic [15:0] h_sw;
    logic [15:0] v_tb;
    logic [15:0] v_act;
    logic [15:0] v_bb;
    logic [15:0] v_sw;
    logic [15:0] v_ext;
    logic [15:0] irq_line;
    logic        ext_ok;
  } vtg_timing_t;

  function automatic vtg_timing_t vtg_profile(input int sel);
    vtg_timing_t t;
    if (sel == 0) begin
      t = '{h_lb: 16'd29, h_act: 16'd321, h_rb: 16'd18, h_sw: 16'd32,
            v_tb: 16'd20, v_act: 16'd224, v_bb: 16'd14, v_sw: 16'd4,
            v_ext: 16'd262, irq_line: 16'd222, ext_ok: 1'b0};
    end else begin
      t = '{h_lb: 16'd69, h_act: 16'd496, h_rb: 16'd43, h_sw: 16'd48,
            v_tb: 16'd25, v_act: 16'd384, v_bb: 16'd11, v_sw: 16'd4,
            v_ext: 16'd512, irq_line: 16'd382, ext_ok: 1'b1};
    end
    return t;
  endfunction

  function automatic int vtg_htot(input vtg_timing_t t);
    return int'(t.h_lb) + int'(t.h_act) + int'(t.h_rb) + int'(t.h_sw);
  endfunction

  function automatic int vtg_vtot(input vtg_timing_t t);
    return int'(t.v_tb) + int'(t.v_act) + int'(t.v_bb) + int'(t.v_sw);
  endfunction

  function automatic int vtg_vmax(input vtg_timing_t t);
    int n;
    n = vtg_vtot(t);
    if (t.ext_ok && int'(t.v_ext) > n) n = int'(t.v_ext);
    return n;
  endfunction

  function automatic int vtg_pix_w(input vtg_timing_t t);
    return $clog2(int'(t.h_act));
  endfunction

  function automatic int vtg_line_w(input vtg_timing_t t);
    return $clog2(vtg_vmax(t));
  endfunction

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
  parameter int HT = 400,
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hc_q,
  output logic [HW-1:0] hc_d,
  output logic          line_end
);

  localparam logic [HW-1:0] H_LAST = HW'(HT - 1);

  always_comb begin
    line_end = (hc_q == H_LAST);
    hc_d     = line_end ? '0 : hc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_q != H_LAST) |=> (hc_q == $past(hc_q) + 1'b1));

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_q == H_LAST) |=> (hc_q == '0));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount #(
  parameter int VT   = 262,
  parameter int VEXT = 262,
  parameter int VW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          ext,
  output logic [VW-1:0] vc_q,
  output logic [VW-1:0] vc_d,
  output logic          frame_end
);

  localparam logic [VW-1:0] V_LAST_N = VW'(VT - 1);
  localparam logic [VW-1:0] V_LAST_E = VW'(VEXT - 1);

  logic [VW-1:0] v_last;

  always_comb begin
    v_last    = ext ? V_LAST_E : V_LAST_N;
    frame_end = (vc_q == v_last);
    vc_d      = vc_q;
    if (adv) vc_d = frame_end ? '0 : vc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vc_q <= '0;
    else if (adv) vc_q <= vc_d;
  end

  a_r10_hold_mid_line: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(vc_q));

  a_r7_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_q <= V_LAST_E) || (vc_q <= V_LAST_N));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
  parameter int HT    = 400,
  parameter int H_LB  = 29,
  parameter int H_ACT = 321,
  parameter int H_SW  = 32,
  parameter int VT    = 262,
  parameter int V_TB  = 20,
  parameter int V_ACT = 224,
  parameter int V_SW  = 4,
  parameter int IRQ_L = 222,
  parameter int HW    = 9,
  parameter int VW    = 9
) (
  input  logic [HW-1:0] hc,
  input  logic [VW-1:0] vc,
  input  logic          ext,
  output logic          hs_n,
  output logic          vs_n,
  output logic          hact,
  output logic          vact,
  output logic          irq_n
);

  localparam logic [HW-1:0] HS_START = HW'(HT - H_SW);
  localparam logic [HW-1:0] HA_START = HW'(H_LB);
  localparam logic [HW-1:0] HA_END   = HW'(H_LB + H_ACT);
  localparam logic [VW-1:0] VS_START = VW'(VT - V_SW);
  localparam logic [VW-1:0] VS_END   = VW'(VT);
  localparam logic [VW-1:0] VA_START = VW'(V_TB);
  localparam logic [VW-1:0] VA_END   = VW'(V_TB + V_ACT);
  localparam logic [VW-1:0] IRQ_V0   = VW'(V_TB + IRQ_L);
  localparam logic [VW-1:0] IRQ_V1   = VW'(V_TB + IRQ_L + 1);

  logic in_hsync;

  always_comb begin
    in_hsync = (hc >= HS_START);
    hs_n     = !in_hsync;
    vs_n     = !((vc >= VS_START) && (vc < VS_END));
    hact     = (hc >= HA_START) && (hc < HA_END);
    vact     = (vc >= VA_START) && (ext || (vc < VA_END));
    irq_n    = !(((vc == IRQ_V0) && in_hsync) || ((vc == IRQ_V1) && !in_hsync));
  end

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int          PROFILE = 0,
  parameter vtg_timing_t T       = vtg_profile(PROFILE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_mode,
  output logic                     hsync_n,
  output logic                     vsync_n,
  output logic                     blank_n,
  output logic                     irq_n,
  output logic [vtg_pix_w(T)-1:0]  pix_x,
  output logic [vtg_line_w(T)-1:0] line_y
);

  localparam int   H_LB   = int'(T.h_lb);
  localparam int   H_ACT  = int'(T.h_act);
  localparam int   H_SW   = int'(T.h_sw);
  localparam int   V_TB   = int'(T.v_tb);
  localparam int   V_ACT  = int'(T.v_act);
  localparam int   V_SW   = int'(T.v_sw);
  localparam int   IRQ_L  = int'(T.irq_line);
  localparam int   HT     = vtg_htot(T);
  localparam int   VT     = vtg_vtot(T);
  localparam int   VEXT   = vtg_vmax(T);
  localparam int   HW     = $clog2(HT);
  localparam int   VW     = $clog2(VEXT);
  localparam int   PW     = vtg_pix_w(T);
  localparam int   LW     = vtg_line_w(T);
  localparam logic EXT_OK = T.ext_ok;

  // reset release synchronizer
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic [HW-1:0] hc_q, hc_d;
  logic [VW-1:0] vc_q, vc_d;
  logic          line_end, frame_end;
  logic          mode_q, mode_d, mode_en;

  vtg_hcount #(.HT(HT), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_i), .hc_q(hc_q), .hc_d(hc_d), .line_end(line_end)
  );

  vtg_vcount #(.VT(VT), .VEXT(VEXT), .VW(VW)) u_v (
    .clk(clk), .rst_n(rst_i), .adv(line_end), .ext(mode_q),
    .vc_q(vc_q), .vc_d(vc_d), .frame_end(frame_end)
  );

  // mode taken only where the frame wraps
  always_comb begin
    mode_en = line_end && frame_end;
    mode_d  = mode_en ? (ext_mode & EXT_OK) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  // decode the next raster position so outputs line up with the counters
  logic hs_d, vs_d, hact_d, vact_d, irq_d;

  vtg_decode #(
    .HT(HT), .H_LB(H_LB), .H_ACT(H_ACT), .H_SW(H_SW),
    .VT(VT), .V_TB(V_TB), .V_ACT(V_ACT), .V_SW(V_SW),
    .IRQ_L(IRQ_L), .HW(HW), .VW(VW)
  ) u_dec (
    .hc(hc_d), .vc(vc_d), .ext(mode_d),
    .hs_n(hs_d), .vs_n(vs_d), .hact(hact_d), .vact(vact_d), .irq_n(irq_d)
  );

  logic [PW-1:0] pix_d, pix_q;
  logic [LW-1:0] lin_d, lin_q;

  always_comb begin
    pix_d = PW'(hc_d - HW'(H_LB));
    lin_d = LW'(vc_d - VW'(V_TB));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      blank_n <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      hsync_n <= hs_d;
      vsync_n <= vs_d;
      blank_n <= hact_d && vact_d;
      irq_n   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      pix_q <= '0;
    else if (hact_d) pix_q <= pix_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      lin_q <= '0;
    else if (vact_d) lin_q <= lin_d;
  end

  assign pix_x  = pix_q;
  assign line_y = lin_q;

  a_r3_sync_in_blank: assert property (@(posedge clk) disable iff (!rst_i)
    !hsync_n |-> !blank_n);

  a_r4_irq_on_hsync_fall: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(irq_n) |-> $fell(hsync_n));

  a_r2_vsync_on_line_start: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(vsync_n) |-> $rose(hsync_n));

  a_r8_mode_at_frame_start: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(mode_q) |-> (hc_q == '0 && vc_q == '0));

  a_r9_mode_unsupported: assert property (@(posedge clk) disable iff (!rst_i)
    !EXT_OK |-> !mode_q);

endmodule

// File: tb/sim_vid_timing_gen.sv
`timescale 1ns/1ps
module sim_vid_timing_gen;
  import vtg_pkg::*;

  localparam vtg_timing_t LOW = vtg_profile(0);
  localparam vtg_timing_t SML = '{h_lb: 16'd3, h_act: 16'd8, h_rb: 16'd2, h_sw: 16'd4,
                                  v_tb: 16'd2, v_act: 16'd6, v_bb: 16'd1, v_sw: 16'd2,
                                  v_ext: 16'd16, irq_line: 16'd4, ext_ok: 1'b1};
  localparam int PW0 = vtg_pix_w(LOW);
  localparam int LW0 = vtg_line_w(LOW);
  localparam int PW1 = vtg_pix_w(SML);
  localparam int LW1 = vtg_line_w(SML);
  localparam int NCYC = 106000;

  logic clk = 1'b0;
  logic rst_n;
  logic mode0, mode1;
  logic hs0, vs0, bl0, iq0, hs1, vs1, bl1, iq1;
  logic [PW0-1:0] px0;
  logic [LW0-1:0] ln0;
  logic [PW1-1:0] px1;
  logic [LW1-1:0] ln1;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vid_timing_gen #(.PROFILE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(mode0),
    .hsync_n(hs0), .vsync_n(vs0), .blank_n(bl0), .irq_n(iq0),
    .pix_x(px0), .line_y(ln0)
  );

  vid_timing_gen #(.PROFILE(1), .T(SML)) u1 (
    .clk(clk), .rst_n(rst_n), .ext_mode(mode1),
    .hsync_n(hs1), .vsync_n(vs1), .blank_n(bl1), .irq_n(iq1),
    .pix_x(px1), .line_y(ln1)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
    end
  endtask

  task automatic check_inst(input string nm, input vtg_timing_t c,
                            input int hc, input int vc, input int mq,
                            input int a_hs, input int a_vs, input int a_bl, input int a_iq,
                            input int a_px, input int a_ln,
                            inout int ep, inout int el,
                            input string vreq, input string breq);
    int ht, vt, hs0_start, vtb, hact, vact, irq_v;
    ht = vtg_htot(c);
    vt = vtg_vtot(c);
    hs0_start = ht - int'(c.h_sw);
    vtb = int'(c.v_tb);
    hact = (hc >= int'(c.h_lb) && hc < int'(c.h_lb) + int'(c.h_act)) ? 1 : 0;
    vact = (vc >= vtb && (mq != 0 || vc < vtb + int'(c.v_act))) ? 1 : 0;
    irq_v = vtb + int'(c.irq_line);
    if (hact != 0) ep = hc - int'(c.h_lb);
    if (vact != 0) el = vc - vtb;
    cmp({"R1 ", nm}, "hsync_n", a_hs, (hc >= hs0_start) ? 0 : 1);
    cmp({vreq, " ", nm}, "vsync_n", a_vs, (vc >= vt - int'(c.v_sw) && vc < vt) ? 0 : 1);
    cmp({breq, " ", nm}, "blank_n", a_bl, hact & vact);
    cmp({"R4 ", nm}, "irq_n", a_iq,
        ((vc == irq_v && hc >= hs0_start) || (vc == irq_v + 1 && hc < hs0_start)) ? 0 : 1);
    cmp({"R5 ", nm}, "pix_x", a_px, ep);
    cmp({breq, "/R5 ", nm}, "line_y", a_ln, el);
  endtask

  task automatic step(input vtg_timing_t c, input logic m, inout int hc, inout int vc, inout int mq);
    int vlast;
    vlast = (mq != 0) ? int'(c.v_ext) - 1 : vtg_vtot(c) - 1;
    if (hc == vtg_htot(c) - 1) begin
      hc = 0;
      if (vc == vlast) begin
        vc = 0;
        mq = (c.ext_ok && m) ? 1 : 0;
      end else vc++;
    end else hc++;
  endtask

  initial begin
    int hc0, vc0, mq0, ep0, el0, hc1, vc1, mq1, ep1, el1;
    hc0 = 0; vc0 = 0; mq0 = 0; ep0 = 0; el0 = 0;
    hc1 = 0; vc1 = 0; mq1 = 0; ep1 = 0; el1 = 0;
    rst_n = 1'b0;
    mode0 = 1'b1;   // R9: low-res profile must ignore this
    mode1 = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R6: reset state observed while reset is held
    cmp("R6", "u0 hsync_n", int'(hs0), 1);
    cmp("R6", "u0 vsync_n", int'(vs0), 1);
    cmp("R6", "u0 blank_n", int'(bl0), 0);
    cmp("R6", "u0 irq_n", int'(iq0), 1);
    cmp("R6", "u0 pix_x", int'(px0), 0);
    cmp("R6", "u0 line_y", int'(ln0), 0);
    cmp("R6", "u1 blank_n", int'(bl1), 0);
    cmp("R6", "u1 line_y", int'(ln1), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NCYC; i++) begin
      t = i;
      check_inst("u0", LOW, hc0, vc0, mq0, int'(hs0), int'(vs0), int'(bl0), int'(iq0),
                 int'(px0), int'(ln0), ep0, el0, "R2/R9/R10", "R3/R9");
      check_inst("u1", SML, hc1, vc1, mq1, int'(hs1), int'(vs1), int'(bl1), int'(iq1),
                 int'(px1), int'(ln1), ep1, el1, "R2/R10", "R3/R7/R8");
      // R8: toggles land mostly mid-frame
      mode1 = ((i / 500) % 2) == 1;
      step(LOW, mode0, hc0, vc0, mq0);
      step(SML, mode1, hc1, vc1, mq1);
      @(negedge clk);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * (NCYC + 20000));
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog t=%0d actual=hung expected=finished", t);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule